// File: doc/BRIEF.md
# Bounded Up/Down Modulo Counter

This block is a 16-bit position counter whose range is set by two programmable boundaries. It does not use the full 0 to 0xFFFF span. It counts one step at a time, up or down. The steps come from one of two sources, picked by a mode input:

- a step strobe paired with a direction level;
- a two-phase quadrature encoder on inputs A and B.

All asynchronous inputs pass through two-flop synchronisers before they are decoded.

There are two boundaries. The upper boundary sits in a compare register with its own staging register, and the lower boundary does the same. When counting up, the counter is checked only against the upper compare. When counting down, it is checked only against the lower compare. At the upper boundary, an up step reloads the counter from the lower staging value. At the lower boundary, a down step reloads it from the upper staging value. Counting never stops.

Each reload also copies both staging registers into the compare registers. Software can therefore prepare new limits that take effect exactly at a wrap. Every reload raises a one-clock wrap pulse that carries the direction of the step that caused it. A single write port sets the boundaries, the staging values and the count itself.

Top module: `wrap_counter`

## Requirements
- R1: After a synchronous reset, count_o is 0, wrap_o is 0, wrap_dir_o is 0 and all four boundary registers hold 0.
- R2: With mode_i=0, each rising edge of the synchronised step_i moves the count by one: up when dir_i is 1, down when dir_i is 0. The count changes on the third rising clock edge after the input changes. A falling edge of step_i does nothing.
- R3: An up step taken while count_o equals the upper compare loads count_o with the lower staging value. It also raises wrap_o for exactly one clock with wrap_dir_o=1.
- R4: A down step taken while count_o equals the lower compare loads count_o with the upper staging value. It also raises wrap_o for exactly one clock with wrap_dir_o=0.
- R5: The direction decides which compare is checked. An up step from the lower compare value just increments. A down step from the upper compare value just decrements. Neither case raises wrap_o.
- R6: With mode_i=1, each single-phase change of the synchronised {A,B} pair counts once. The order 00→10→11→01→00 (A leading) counts up, and the reverse order counts down.
- R7: In quadrature mode, a change of both A and B between two synchronised samples leaves the count unchanged and raises no wrap.
- R8: The inputs of the mode not selected have no effect on the count. That means step_i and dir_i when mode_i=1, and qa_i and qb_i when mode_i=0.
- R9: On every wrap, both compare registers take the values their staging registers held before that clock edge. A staging write therefore moves a limit only at the next wrap.
- R10: A write with wr_en_i=1 stores wr_data_i into the register picked by wr_sel_i: 0 upper compare, 1 lower compare, 2 upper staging, 3 lower staging, 4 count. A count write takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = step/direction source, 1 = quadrature source |
| step_i | input | 1 | Step strobe, counted on its rising edge |
| dir_i | input | 1 | Direction for step_i, 1 = up |
| qa_i | input | 1 | Quadrature phase A |
| qb_i | input | 1 | Quadrature phase B |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| wrap_o | output | 1 | One-clock pulse on each boundary reload |
| wrap_dir_o | output | 1 | Direction of the latest wrap, 1 = up |

## Verification
The assertions are checked on every cycle against the decoded step and the live register contents. They cover:
- the plus-one and minus-one steps away from the active boundary;
- the reload value and tagged pulse at each boundary;
- holding when no step is decoded;
- the count write;
- the copy of the staging values at a wrap.

Some behaviour needs whole scenarios driven at the pins, so only the bench can show it. The bench checks the synchroniser latency and the quadrature phase order. It checks that double transitions and the inputs of the unselected mode are rejected. It also checks that staged limits take effect only after a wrap, using full sweeps across both boundaries in both directions.

// File: rtl/wrapcnt_pkg.sv
package wrapcnt_pkg;

    localparam int unsigned CNT_W_DEF   = 16;
    localparam int unsigned SYNC_DEF    = 2;
    localparam int unsigned SEL_W       = 3;
    localparam int unsigned RAW_INPUTS  = 4;

    typedef enum logic {
        SRC_STEPDIR = 1'b0,
        SRC_QUAD    = 1'b1
    } src_mode_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMP_HI = 3'd0,
        SEL_CMP_LO = 3'd1,
        SEL_PRE_HI = 3'd2,
        SEL_PRE_LO = 3'd3,
        SEL_COUNT  = 3'd4
    } wsel_e;

    typedef struct packed {
        logic valid;
        logic up;
    } move_t;

    // {a,b} phase pairs; A leading B counts up.
    function automatic move_t quad_move(input logic [1:0] prev, input logic [1:0] cur);
        move_t m;
        m.valid = 1'b0;
        m.up    = 1'b0;
        case ({prev, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: begin
                m.valid = 1'b1;
                m.up    = 1'b1;
            end
            4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: begin
                m.valid = 1'b1;
                m.up    = 1'b0;
            end
            default: begin
                m.valid = 1'b0;
                m.up    = 1'b0;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wc_move_src.sv
module wc_move_src
    import wrapcnt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  src_mode_e mode,
    input  logic      step,
    input  logic      dir,
    input  logic      qa,
    input  logic      qb,
    output move_t     mv
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    // bit order inside each stage: {qa, qb, dir, step}
    logic [RAW_INPUTS-1:0] stg [SYNC_STAGES];
    logic [RAW_INPUTS-1:0] raw;
    logic                  step_q;
    logic [1:0]            ab_q;
    logic                  step_s;
    logic                  dir_s;
    logic [1:0]            ab_s;
    move_t                 mv_step;
    move_t                 mv_quad;

    assign raw = {qa, qb, dir, step};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(SYNC_STAGES); i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign step_s = stg[LAST][0];
    assign dir_s  = stg[LAST][1];
    assign ab_s   = stg[LAST][3:2];

    // both histories advance in either mode so a mode change makes no phantom step
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= 1'b0;
            ab_q   <= 2'b00;
        end else begin
            step_q <= step_s;
            ab_q   <= ab_s;
        end
    end

    always_comb begin
        mv_step.valid = step_s & ~step_q;
        mv_step.up    = dir_s;
        mv_quad       = quad_move(ab_q, ab_s);
        mv            = (mode == SRC_QUAD) ? mv_quad : mv_step;
    end

endmodule

// File: rtl/wc_bound_regs.sv
module wc_bound_regs
    import wrapcnt_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  wsel_e        wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         wrap_hit,
    output logic [W-1:0] cmp_hi,
    output logic [W-1:0] cmp_lo,
    output logic [W-1:0] pre_hi,
    output logic [W-1:0] pre_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_hi <= '0;
            pre_lo <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PRE_HI) pre_hi <= wr_data;
            if (wr_sel == SEL_PRE_LO) pre_lo <= wr_data;
        end
    end

    // a direct compare write wins over the wrap-time copy
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_hi <= '0;
            cmp_lo <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_CMP_HI) cmp_hi <= wr_data;
            else if (wrap_hit)                 cmp_hi <= pre_hi;
            if (wr_en && wr_sel == SEL_CMP_LO) cmp_lo <= wr_data;
            else if (wrap_hit)                 cmp_lo <= pre_lo;
        end
    end

endmodule

// File: rtl/wc_count_core.sv
module wc_count_core
    import wrapcnt_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  move_t        mv,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] cmp_hi,
    input  logic [W-1:0] cmp_lo,
    input  logic [W-1:0] pre_hi,
    input  logic [W-1:0] pre_lo,
    output logic         hit,
    output logic [W-1:0] count,
    output logic         wrap,
    output logic         wrap_dir
);
    logic         hit_up;
    logic         hit_dn;
    logic [W-1:0] nxt;

    always_comb begin
        hit_up = mv.valid &  mv.up & (count == cmp_hi) & ~ld_en;
        hit_dn = mv.valid & ~mv.up & (count == cmp_lo) & ~ld_en;
        hit    = hit_up | hit_dn;
        if (ld_en)        nxt = ld_val;
        else if (hit_up)  nxt = pre_lo;
        else if (hit_dn)  nxt = pre_hi;
        else if (mv.valid) nxt = mv.up ? count + W'(1) : count - W'(1);
        else              nxt = count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            wrap     <= 1'b0;
            wrap_dir <= 1'b0;
        end else begin
            count <= nxt;
            wrap  <= hit;
            if (hit) wrap_dir <= hit_up;
        end
    end

endmodule

// File: rtl/wrap_counter.sv
module wrap_counter
    import wrapcnt_pkg::*;
#(
    parameter int unsigned W           = CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic             qa_i,
    input  logic             qb_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [W-1:0]     wr_data_i,
    output logic [W-1:0]     count_o,
    output logic             wrap_o,
    output logic             wrap_dir_o
);
    move_t        mv;
    logic         mv_valid;
    logic         mv_up;
    logic         ld_en;
    logic         hit;
    wsel_e        sel;
    src_mode_e    mode;
    logic [W-1:0] cmp_hi;
    logic [W-1:0] cmp_lo;
    logic [W-1:0] pre_hi;
    logic [W-1:0] pre_lo;

    assign sel      = wsel_e'(wr_sel_i);
    assign mode     = src_mode_e'(mode_i);
    assign ld_en    = wr_en_i && (sel == SEL_COUNT);
    assign mv_valid = mv.valid;
    assign mv_up    = mv.up;

    wc_move_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .step (step_i),
        .dir  (dir_i),
        .qa   (qa_i),
        .qb   (qb_i),
        .mv   (mv)
    );

    wc_bound_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en_i),
        .wr_sel   (sel),
        .wr_data  (wr_data_i),
        .wrap_hit (hit),
        .cmp_hi   (cmp_hi),
        .cmp_lo   (cmp_lo),
        .pre_hi   (pre_hi),
        .pre_lo   (pre_lo)
    );

    wc_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .mv       (mv),
        .ld_en    (ld_en),
        .ld_val   (wr_data_i),
        .cmp_hi   (cmp_hi),
        .cmp_lo   (cmp_lo),
        .pre_hi   (pre_hi),
        .pre_lo   (pre_lo),
        .hit      (hit),
        .count    (count_o),
        .wrap     (wrap_o),
        .wrap_dir (wrap_dir_o)
    );

endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         mv_valid,
    input logic         mv_up,
    input logic         ld_en,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_hi,
    input logic [W-1:0] cmp_lo,
    input logic [W-1:0] pre_hi,
    input logic [W-1:0] pre_lo,
    input logic         wrap,
    input logic         wrap_dir
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !wrap && !wrap_dir));

    p_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_up && !ld_en && count != cmp_hi)
        |=> (count == W'($past(count) + 1'b1) && !wrap));

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_up && !ld_en && count != cmp_lo)
        |=> (count == W'($past(count) - 1'b1) && !wrap));

    p_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_up && !ld_en && count == cmp_hi)
        |=> (count == $past(pre_lo) && wrap && wrap_dir));

    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_up && !ld_en && count == cmp_lo)
        |=> (count == $past(pre_hi) && wrap && !wrap_dir));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!mv_valid && !ld_en) |=> ($stable(count) && !wrap));

    p_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !wr_en && ((mv_up && count == cmp_hi) || (!mv_up && count == cmp_lo)))
        |=> (cmp_hi == $past(pre_hi) && cmp_lo == $past(pre_lo)));

    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (count == $past(wr_data) && !wrap));

endmodule

bind wrap_counter wc_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mv_valid (mv_valid),
    .mv_up    (mv_up),
    .ld_en    (ld_en),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .count    (count_o),
    .cmp_hi   (cmp_hi),
    .cmp_lo   (cmp_lo),
    .pre_hi   (pre_hi),
    .pre_lo   (pre_lo),
    .wrap     (wrap_o),
    .wrap_dir (wrap_dir_o)
);

// File: tb/sim_wrap_counter.sv
module sim_wrap_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b0;
    logic        step_i = 1'b0;
    logic        dir_i = 1'b0;
    logic        qa_i = 1'b0;
    logic        qb_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] count_o;
    logic        wrap_o;
    logic        wrap_dir_o;

    int checks = 0;
    int failures = 0;
    int wrap_seen = 0;
    logic last_wdir = 1'b0;

    // bench model
    int m_cnt, m_chi, m_clo, m_phi, m_plo, m_wraps;
    logic m_wdir;
    int qpos = 0;

    always #2.5 clk = ~clk;

    wrap_counter u0 (
        .clk(clk), .rst(rst), .mode_i(mode_i), .step_i(step_i), .dir_i(dir_i),
        .qa_i(qa_i), .qb_i(qb_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .count_o(count_o), .wrap_o(wrap_o), .wrap_dir_o(wrap_dir_o)
    );

    always @(negedge clk) begin
        if (!rst && wrap_o) begin
            wrap_seen++;
            last_wdir = wrap_dir_o;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = 16'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
        case (sel)
            0: m_chi = data;
            1: m_clo = data;
            2: m_phi = data;
            3: m_plo = data;
            default: m_cnt = data;
        endcase
    endtask

    task automatic model_step(input logic up);
        if (up) begin
            if (m_cnt == m_chi) begin
                m_cnt = m_plo; m_wraps++; m_wdir = 1'b1; m_chi = m_phi; m_clo = m_plo;
            end else m_cnt = (m_cnt + 1) & 16'hFFFF;
        end else begin
            if (m_cnt == m_clo) begin
                m_cnt = m_phi; m_wraps++; m_wdir = 1'b0; m_chi = m_phi; m_clo = m_plo;
            end else m_cnt = (m_cnt - 1) & 16'hFFFF;
        end
    endtask

    task automatic check_state(input string req);
        check(req, int'(count_o), m_cnt);
        check(req, wrap_seen, m_wraps);
        if (m_wraps > 0) check(req, int'(last_wdir), int'(m_wdir));
    endtask

    task automatic sd_step(input logic up);
        @(negedge clk);
        dir_i = up; step_i = 1'b1;
        repeat (3) @(negedge clk);
        step_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_q(input int pos);
        logic [1:0] ab;
        case (pos & 3)
            0: ab = 2'b00;
            1: ab = 2'b10;
            2: ab = 2'b11;
            default: ab = 2'b01;
        endcase
        @(negedge clk);
        qa_i = ab[1]; qb_i = ab[0];
        repeat (5) @(negedge clk);
    endtask

    task automatic q_step(input logic up);
        qpos = up ? (qpos + 1) & 3 : (qpos + 3) & 3;
        set_q(qpos);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_cnt = 0; m_chi = 0; m_clo = 0; m_phi = 0; m_plo = 0; m_wraps = 0; m_wdir = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(count_o), 0);
        check("R1", int'(wrap_o), 0);
        check("R1", int'(wrap_dir_o), 0);

        // R10 register writes
        wr(0, 9); wr(1, 3); wr(2, 9); wr(3, 3); wr(4, 5);
        check("R10", int'(count_o), 5);

        // R2/R3 up sweep, R2/R4 down sweep, step/direction mode
        for (int i = 0; i < 16; i++) begin
            sd_step(1'b1); model_step(1'b1);
            check((count_o == 16'(m_plo) && wrap_seen > 0) ? "R3" : "R2", int'(count_o), m_cnt);
            check_state("R3");
        end
        for (int i = 0; i < 16; i++) begin
            sd_step(1'b0); model_step(1'b0);
            check_state("R4");
        end
        check("R2", int'(wrap_seen >= 4), 1);

        // R5 direction picks the compare
        wr(4, 3); sd_step(1'b1); model_step(1'b1); check_state("R5");
        check("R5", int'(count_o), 4);
        wr(4, 9); sd_step(1'b0); model_step(1'b0); check_state("R5");
        check("R5", int'(count_o), 8);

        // R9 staged limits take effect at the wrap
        wr(2, 12); wr(3, 1); wr(4, 8);
        for (int i = 0; i < 18; i++) begin
            sd_step(1'b1); model_step(1'b1); check_state("R9");
        end
        for (int i = 0; i < 18; i++) begin
            sd_step(1'b0); model_step(1'b0); check_state("R9");
        end

        // R6 quadrature sweeps
        mode_i = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            q_step(1'b1); model_step(1'b1); check_state("R6");
        end
        for (int i = 0; i < 30; i++) begin
            q_step(1'b0); model_step(1'b0); check_state("R6");
        end

        // R7 double transitions ignored
        qpos = (qpos + 2) & 3; set_q(qpos); check_state("R7");
        qpos = (qpos + 2) & 3; set_q(qpos); check_state("R7");
        q_step(1'b1); model_step(1'b1); check_state("R7");

        // R8 step/dir ignored in quadrature mode
        sd_step(1'b1); check_state("R8");
        sd_step(1'b0); check_state("R8");
        // R8 A/B ignored in step/dir mode
        mode_i = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            q_step(1'b1); check_state("R8");
        end
        sd_step(1'b1); model_step(1'b1); check_state("R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule